// File: doc/BRIEF.md
# Hysteresis Indirect Branch Target Buffer

This block predicts where an indirect jump will go. In the fetch stage the core presents the address of a jump instruction on the lookup port. In the same cycle the block returns a hit flag and the predicted destination. Once the jump resolves, the core presents the same instruction address and the destination actually taken on the update port. Return instructions are not sent to this table.

The storage is a direct-mapped table of 2^IDX_W entries. Each entry holds a valid bit, an address tag, a stored target and one hysteresis bit. The entry is indexed by the address bits just above the instruction alignment bits, and the higher bits are kept as the tag. The stored target is not replaced on the first wrong prediction. The first miss only arms the hysteresis bit, and the target is overwritten only if the next update of that entry is also wrong. A jump that mostly goes to one place therefore keeps that place through a single exception.

The update port is a valid/ready stream. The block never exerts back-pressure in normal operation: `upd_ready` is high in every cycle except the cycles in which reset is asserted. An update is taken on a clock edge where `upd_valid` and `upd_ready` are both high. The lookup port has no ready, because it is answered in the same cycle.

Top module: `ibtb_hyst`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every entry, so all later lookups miss until an update is accepted. `upd_ready` is low in every cycle in which `rst` is high.
- R2: `lkp_hit` is high only when `lkp_valid` is high, the indexed entry is valid and its stored tag equals the tag bits of `lkp_pc`. On a hit, `lkp_target` is the stored target; otherwise `lkp_target` is zero.
- R3: With the default parameters the index is `pc[7:2]` and the tag is `pc[31:8]`. The two alignment bits `pc[1:0]` have no effect. Two addresses that share an index but differ in tag compete for one entry.
- R4: An accepted update whose address misses (entry invalid or tag different) allocates the entry at once with the actual target and a clear hysteresis bit.
- R5: An accepted update that hits with a matching target clears the hysteresis bit. After this, a single wrong update does not replace the target.
- R6: An accepted update that hits with a different target while the hysteresis bit is clear keeps the stored target and sets the bit.
- R7: An accepted update that hits with a different target while the hysteresis bit is set replaces the stored target with the new actual target and clears the bit.
- R8: An update takes effect at the clock edge that accepts it. A lookup of the same entry in the accepting cycle sees the old contents, and a lookup in the next cycle sees the new contents.
- R9: When `upd_valid` is low, no entry changes. `upd_ready` is high in every cycle in which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lkp_valid | input | 1 | Lookup request present |
| lkp_pc | input | ADDR_W | Address of the indirect jump being fetched |
| lkp_hit | output | 1 | Prediction available |
| lkp_target | output | ADDR_W | Predicted destination (zero when no hit) |
| upd_valid | input | 1 | Resolved jump offered for training |
| upd_ready | output | 1 | Update accepted this cycle (low only during reset) |
| upd_pc | input | ADDR_W | Address of the resolved jump |
| upd_target | input | ADDR_W | Destination the jump actually took |

## Verification
A lookup and an update can address the same entry in one cycle. This happens when fetch meets a jump while an older instance of that jump is still being trained. The bench provokes this on purpose in its directed sequences and often in a random phase that draws both addresses from a small pool, where aliasing addresses share indexes. A behavioural model answers each lookup from its state before the edge and applies the update only after the edge, so every cycle checks that the combined lookup sees old contents and that the next cycle sees the trained entry.

// File: rtl/ibtb_pkg.sv
package ibtb_pkg;

  // How a resolved jump changes the entry it addresses.
  typedef enum logic [1:0] {
    UPD_ALLOC   = 2'd0,  // miss: take the entry over
    UPD_CONFIRM = 2'd1,  // hit, target right: calm the entry
    UPD_ARM     = 2'd2,  // hit, first wrong target: keep it, arm
    UPD_REPLACE = 2'd3   // hit, second wrong target: overwrite
  } upd_kind_e;

endpackage

// File: rtl/ibtb_addr_split.sv
module ibtb_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int ALIGN_W = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - ALIGN_W
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  logic unused_align;

  assign idx          = pc[ALIGN_W +: IDX_W];
  assign tag          = pc[ADDR_W-1 -: TAG_W];
  assign unused_align = ^pc[ALIGN_W-1:0];

endmodule

// File: rtl/ibtb_table.sv
module ibtb_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  // read port A (lookup)
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_tgt,
  // read port B (update side)
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [ADDR_W-1:0] rb_tgt,
  output logic              rb_hyst,
  // write port
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic              wr_hyst
);

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] hyst_vec;
  logic [TAG_W-1:0]   tag_arr [ENTRIES];
  logic [ADDR_W-1:0]  tgt_arr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              v_q;
    logic              h_q;
    logic [TAG_W-1:0]  t_q;
    logic [ADDR_W-1:0] d_q;
    logic              sel;

    assign sel = we && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        h_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
        h_q <= wr_hyst;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst && sel) begin
        t_q <= wr_tag;
        d_q <= wr_tgt;
      end
    end

    assign valid_vec[e] = v_q;
    assign hyst_vec[e]  = h_q;
    assign tag_arr[e]   = t_q;
    assign tgt_arr[e]   = d_q;
  end

  assign ra_valid = valid_vec[ra_idx];
  assign ra_tag   = tag_arr[ra_idx];
  assign ra_tgt   = tgt_arr[ra_idx];

  assign rb_valid = valid_vec[rb_idx];
  assign rb_tag   = tag_arr[rb_idx];
  assign rb_tgt   = tgt_arr[rb_idx];
  assign rb_hyst  = hyst_vec[rb_idx];

endmodule

// File: rtl/ibtb_update_ctrl.sv
module ibtb_update_ctrl
  import ibtb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 24
) (
  input  logic              cur_valid,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic [ADDR_W-1:0] cur_tgt,
  input  logic              cur_hyst,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ADDR_W-1:0] req_tgt,
  output logic [TAG_W-1:0]  new_tag,
  output logic [ADDR_W-1:0] new_tgt,
  output logic              new_hyst
);

  upd_kind_e kind;
  logic      tag_hit;
  logic      tgt_same;

  assign tag_hit  = cur_valid && (cur_tag == req_tag);
  assign tgt_same = (cur_tgt == req_tgt);

  always_comb begin
    if (!tag_hit)      kind = UPD_ALLOC;
    else if (tgt_same) kind = UPD_CONFIRM;
    else if (!cur_hyst) kind = UPD_ARM;
    else               kind = UPD_REPLACE;
  end

  always_comb begin
    new_tag  = req_tag;
    new_tgt  = cur_tgt;
    new_hyst = 1'b0;
    unique case (kind)
      UPD_ALLOC:   new_tgt  = req_tgt;
      UPD_CONFIRM: new_hyst = 1'b0;
      UPD_ARM:     new_hyst = 1'b1;
      UPD_REPLACE: new_tgt  = req_tgt;
      default:     new_hyst = 1'b0;
    endcase
  end

endmodule

// File: rtl/ibtb_hyst.sv
module ibtb_hyst #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_pc,
  output logic              lkp_hit,
  output logic [ADDR_W-1:0] lkp_target,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target
);

  localparam int TAG_W = ADDR_W - IDX_W - ALIGN_W;

  logic [IDX_W-1:0]  l_idx, u_idx;
  logic [TAG_W-1:0]  l_tag, u_tag;
  logic              a_valid, b_valid, b_hyst;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [ADDR_W-1:0] a_tgt, b_tgt;
  logic [TAG_W-1:0]  w_tag;
  logic [ADDR_W-1:0] w_tgt;
  logic              w_hyst;
  logic              accept;

  ibtb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_split_lkp (
    .pc(lkp_pc), .idx(l_idx), .tag(l_tag)
  );

  ibtb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_split_upd (
    .pc(upd_pc), .idx(u_idx), .tag(u_tag)
  );

  ibtb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .ra_idx  (l_idx),
    .ra_valid(a_valid),
    .ra_tag  (a_tag),
    .ra_tgt  (a_tgt),
    .rb_idx  (u_idx),
    .rb_valid(b_valid),
    .rb_tag  (b_tag),
    .rb_tgt  (b_tgt),
    .rb_hyst (b_hyst),
    .we      (accept),
    .wr_idx  (u_idx),
    .wr_tag  (w_tag),
    .wr_tgt  (w_tgt),
    .wr_hyst (w_hyst)
  );

  ibtb_update_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_ctrl (
    .cur_valid(b_valid),
    .cur_tag  (b_tag),
    .cur_tgt  (b_tgt),
    .cur_hyst (b_hyst),
    .req_tag  (u_tag),
    .req_tgt  (upd_target),
    .new_tag  (w_tag),
    .new_tgt  (w_tgt),
    .new_hyst (w_hyst)
  );

  // Update stream: never stalls except while the table is being cleared.
  assign upd_ready = !rst;
  assign accept    = upd_valid && upd_ready;

  // Lookup: combinational read of registered state.
  assign lkp_hit    = lkp_valid && a_valid && (a_tag == l_tag);
  assign lkp_target = lkp_hit ? a_tgt : '0;

endmodule

// File: rtl/ibtb_hyst_chk.sv
module ibtb_hyst_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lkp_valid,
  input logic [ADDR_W-1:0] lkp_pc,
  input logic              lkp_hit,
  input logic [ADDR_W-1:0] lkp_target,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [ADDR_W-1:0] upd_pc
);

  logic seen_upd;
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_upd <= 1'b0;
      past_ok  <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (upd_valid && upd_ready) seen_upd <= 1'b1;
    end
  end

  // R1: no back-pressure source other than reset, which must stall.
  always @(posedge clk) begin
    if (rst) a_r1_ready_low_in_reset: assert (!upd_ready);
  end

  // R1: nothing can hit until something has been trained after reset.
  a_r1_no_hit_before_train: assert property (@(posedge clk) disable iff (rst)
    !seen_upd |-> !lkp_hit);

  // R2: hit needs a request; a non-hit carries a zero target.
  a_r2_hit_needs_request: assert property (@(posedge clk) disable iff (rst)
    lkp_hit |-> lkp_valid);

  a_r2_miss_target_zero: assert property (@(posedge clk) disable iff (rst)
    !lkp_hit |-> (lkp_target == '0));

  // R8: an entry trained last cycle hits for the same address now.
  a_r8_trained_entry_hits: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(upd_valid && upd_ready) && lkp_valid &&
     (lkp_pc == $past(upd_pc))) |-> lkp_hit);

  // R9: with no accepted update, a repeated lookup gives the same answer.
  a_r9_quiet_is_stable: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(upd_valid && upd_ready) && $past(lkp_valid) &&
     lkp_valid && (lkp_pc == $past(lkp_pc)))
    |-> ($stable(lkp_hit) && $stable(lkp_target)));

endmodule

bind ibtb_hyst ibtb_hyst_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lkp_valid (lkp_valid),
  .lkp_pc    (lkp_pc),
  .lkp_hit   (lkp_hit),
  .lkp_target(lkp_target),
  .upd_valid (upd_valid),
  .upd_ready (upd_ready),
  .upd_pc    (upd_pc)
);

// File: tb/ibtb_hyst_tb.sv
`timescale 1ns/1ps
module ibtb_hyst_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        lkp_valid;
  logic [31:0] lkp_pc;
  logic        lkp_hit;
  logic [31:0] lkp_target;
  logic        upd_valid;
  logic        upd_ready;
  logic [31:0] upd_pc;
  logic [31:0] upd_target;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ibtb_hyst u_dut (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .lkp_hit(lkp_hit), .lkp_target(lkp_target),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_pc(upd_pc), .upd_target(upd_target)
  );

  // Behavioural reference: slot keyed by pc[7:2], owner by pc[31:8].
  bit          m_v   [int];
  logic [23:0] m_own [int];
  logic [31:0] m_dst [int];
  bit          m_arm [int];

  function automatic void model_clear();
    m_v.delete(); m_own.delete(); m_dst.delete(); m_arm.delete();
  endfunction

  function automatic void model_predict(input logic lv, input logic [31:0] pc,
                                        output logic h, output logic [31:0] t);
    int k = int'(pc[7:2]);
    h = 1'b0; t = 32'h0;
    if (lv && m_v.exists(k) && m_own[k] == pc[31:8]) begin
      h = 1'b1; t = m_dst[k];
    end
  endfunction

  function automatic void model_train(input logic [31:0] pc, input logic [31:0] dst);
    int k = int'(pc[7:2]);
    if (!m_v.exists(k) || m_own[k] != pc[31:8]) begin
      m_v[k] = 1'b1; m_own[k] = pc[31:8]; m_dst[k] = dst; m_arm[k] = 1'b0;
    end else if (m_dst[k] == dst) begin
      m_arm[k] = 1'b0;
    end else if (!m_arm[k]) begin
      m_arm[k] = 1'b1;
    end else begin
      m_dst[k] = dst; m_arm[k] = 1'b0;
    end
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, compare, then let the edge act.
  task automatic step(input bit r, input bit lv, input logic [31:0] lpc,
                      input bit uv, input logic [31:0] upc,
                      input logic [31:0] utg, input string req);
    logic        eh;
    logic [31:0] et;
    @(negedge clk);
    rst = r; lkp_valid = lv; lkp_pc = lpc;
    upd_valid = uv; upd_pc = upc; upd_target = utg;
    #1;
    model_predict(lv, lpc, eh, et);
    chk({31'h0, lkp_hit}, {31'h0, eh}, req, "hit");
    chk(lkp_target, et, req, "target");
    chk({31'h0, upd_ready}, {31'h0, !r}, r ? "R1" : "R9", "ready");
    @(posedge clk);
    if (r) model_clear();
    else if (uv) model_train(upc, utg);
  endtask

  localparam logic [31:0] PA = 32'h0000_1040;  // slot 0x10
  localparam logic [31:0] PB = 32'h0000_2040;  // same slot, other owner
  localparam logic [31:0] T1 = 32'h0000_8000;
  localparam logic [31:0] T2 = 32'h0000_9000;
  localparam logic [31:0] T3 = 32'h0000_A000;
  localparam logic [31:0] TB = 32'h0000_B000;
  localparam logic [31:0] POOL [6] = '{32'h0000_1040, 32'h0000_2040,
    32'h0000_1044, 32'h0000_3080, 32'h0004_1040, 32'h0000_10C0};

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    rst = 1'b1; lkp_valid = 1'b0; lkp_pc = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_target = '0;
    model_clear();

    // R1: reset clears, ready is low meanwhile
    repeat (3) step(1, 0, PA, 1, PA, T1, "R1");
    for (int i = 0; i < 6; i++) step(0, 1, POOL[i], 0, 0, 0, "R1");

    // R2: no request, no hit
    step(0, 0, PA, 0, 0, 0, "R2");

    // R8 + R4: allocate while looking up the same jump, then see it
    step(0, 1, PA, 1, PA, T1, "R8");
    step(0, 1, PA, 0, 0, 0, "R4");

    // R6: first wrong target keeps T1
    step(0, 1, PA, 1, PA, T2, "R6");
    step(0, 1, PA, 0, 0, 0, "R6");

    // R5: a correct update disarms, so one wrong update keeps T1 again
    step(0, 1, PA, 1, PA, T1, "R5");
    step(0, 1, PA, 1, PA, T2, "R5");
    step(0, 1, PA, 0, 0, 0, "R5");

    // R7: second wrong in a row replaces (with the newest target T3)
    step(0, 1, PA, 1, PA, T3, "R7");
    step(0, 1, PA, 0, 0, 0, "R7");

    // R3: alignment bits ignored; alias misses, then steals the slot
    step(0, 1, PA | 32'h3, 0, 0, 0, "R3");
    step(0, 1, PB, 1, PB, TB, "R3");
    step(0, 1, PB, 0, 0, 0, "R3");
    step(0, 1, PA, 0, 0, 0, "R3");

    // R9: invalid update data has no effect
    step(0, 1, PB, 0, PB, T1, "R9");
    step(0, 1, PB, 0, PB, T2, "R9");
    step(0, 1, PB, 0, 0, 0, "R9");

    // mixed traffic over a small aliasing pool, checked every cycle
    for (int n = 0; n < 4000; n++) begin
      int li = $urandom_range(0, 5);
      int ui = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 5) : li;
      logic [31:0] tg = 32'h0000_8000 + 32'($urandom_range(0, 2)) * 32'h1000;
      step(0, $urandom_range(0, 7) != 0, POOL[li],
           $urandom_range(0, 9) < 6, POOL[ui], tg, "R2");
    end

    // R1: a mid-run reset forgets everything
    step(1, 0, PA, 0, 0, 0, "R1");
    for (int i = 0; i < 6; i++) step(0, 1, POOL[i], 0, 0, 0, "R1");

    finish_run();
  end

endmodule